// File: doc/BRIEF.md
# Adaptive-to-Escape Virtual Channel Selector

This block sits in the route-compute stage of a two-dimensional mesh router. For each packet header it picks an output port and an output virtual channel. Each output has two kinds of virtual channel. The adaptive kind may be taken on any output that moves the packet closer to its destination. One escape channel per output may be taken only along the deterministic route, which corrects X first and then Y.

A header starts in adaptive mode. When none of the adaptive channels on its useful outputs is free in a cycle, the header falls back to the escape channel of its dimension-ordered output. At that point its mode bit is set and written back with the decision. A header whose mode bit is already set never returns to adaptive channels. A round-robin pointer spreads adaptive choices across both dimensions and across channel indices. When the header has arrived, it is sent to the local port whatever its mode. Buffers, switch allocation and the crossbar belong to neighbouring blocks.

Top module: `rt_escape_vc_sel`

## Requirements
- R1: While `hdr_valid` is low, `grant` is low and the round-robin pointer keeps its value. After reset the pointer is at slot 0.
- R2: When the current and destination coordinates are equal, the block picks port 0 (local) and the lowest-index free channel of that port, in either mode, and `esc_out` equals `esc_in`. If no local channel is free, `grant` is low.
- R3: In adaptive mode (`esc_in`=0), the candidates are the adaptive channels 0..NUM_AVC-1 on the useful outputs only. Port codes are 1 for +X, 2 for -X, 3 for +Y and 4 for -Y. A grant on a candidate drives `esc_out` low.
- R4: Adaptive candidates are numbered slot = 2*vc + dim, where dim is 0 for X and 1 for Y. The search starts at the pointer and takes the first free slot. After an adaptive grant the pointer moves to the chosen slot plus one, wrapping at 2*NUM_AVC. It does not move after an escape grant, a local grant or no grant.
- R5: In adaptive mode with no adaptive candidate free, the block grants escape channel NUM_AVC on the dimension-ordered output (X while X differs, else Y) if that channel is free, and drives `esc_out` high.
- R6: If the escape channel needed is busy, `grant` is low and `esc_out` equals `esc_in`.
- R7: With `esc_in`=1 the block only ever uses escape channel NUM_AVC on the dimension-ordered output, even when adaptive channels are free, and `esc_out` stays high.
- R8: Any granted channel is free. Channel c of port p is bit p*(NUM_AVC+1)+c of `vc_free`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| hdr_valid | input | 1 | A header is presented this cycle |
| cur_x | input | X_W | This router's X coordinate |
| cur_y | input | Y_W | This router's Y coordinate |
| dst_x | input | X_W | Destination X coordinate |
| dst_y | input | Y_W | Destination Y coordinate |
| esc_in | input | 1 | Header mode bit: 1 once the packet has entered the escape class |
| vc_free | input | 5*(NUM_AVC+1) | Per-port, per-channel free flags |
| grant | output | 1 | A port and channel were chosen |
| out_port | output | 3 | Chosen port code |
| out_vc | output | clog2(NUM_AVC+1) | Chosen channel index |
| esc_out | output | 1 | Updated mode bit for the header |

## Verification
The bench goes after several ways the selection can go wrong:
- The fallback moment: a design that left adaptive mode too early would take the escape channel while an adaptive one was still free. One that never fell back would stall with the escape channel free.
- The one-way mode bit: after escape entry the bench offers free adaptive channels. A design that let the packet return would grant one and clear `esc_out`.
- The pointer's fairness: sequences show whether the pointer alternates dimensions, wraps, and holds through idle and escape cycles. A wrong update repeats a slot or skips one.
- Corner cases: arrival with the low local channel busy, free channels on outputs that do not move the packet, and a busy escape channel. Each of these gives a wrong port or a spurious grant on a faulty design.

// File: rtl/rt_vc_pkg.sv
package rt_vc_pkg;

    localparam int NUM_PORTS = 5;

    typedef enum logic [2:0] {
        PORT_LOCAL = 3'd0,
        PORT_XPOS  = 3'd1,
        PORT_XNEG  = 3'd2,
        PORT_YPOS  = 3'd3,
        PORT_YNEG  = 3'd4
    } port_e;

    typedef struct packed {
        logic  at_dest;
        logic  x_move;
        logic  y_move;
        port_e x_port;
        port_e y_port;
        port_e dor_port;
    } route_info_t;

endpackage

// File: rtl/rt_dir.sv
module rt_dir
    import rt_vc_pkg::*;
#(
    parameter int X_W = 3,
    parameter int Y_W = 3
) (
    input  logic [X_W-1:0] cur_x,
    input  logic [Y_W-1:0] cur_y,
    input  logic [X_W-1:0] dst_x,
    input  logic [Y_W-1:0] dst_y,
    output route_info_t    info
);
    always_comb begin
        info.x_move  = (cur_x != dst_x);
        info.y_move  = (cur_y != dst_y);
        info.x_port  = (dst_x > cur_x) ? PORT_XPOS : PORT_XNEG;
        info.y_port  = (dst_y > cur_y) ? PORT_YPOS : PORT_YNEG;
        info.at_dest = !info.x_move && !info.y_move;
        if (info.x_move)      info.dor_port = info.x_port;
        else if (info.y_move) info.dor_port = info.y_port;
        else                  info.dor_port = PORT_LOCAL;
    end
endmodule

// File: rtl/rt_first_free.sv
module rt_first_free #(
    parameter int N = 3,
    localparam int IW = (N > 1) ? $clog2(N) : 1
) (
    input  logic [N-1:0]  free,
    output logic          found,
    output logic [IW-1:0] idx
);
    always_comb begin
        found = 1'b0;
        idx   = '0;
        for (int i = 0; i < N; i++) begin
            if (!found && free[i]) begin
                found = 1'b1;
                idx   = IW'(i);
            end
        end
    end
endmodule

// File: rtl/rt_rr_pick.sv
module rt_rr_pick #(
    parameter int N = 4,
    localparam int IW = (N > 1) ? $clog2(N) : 1
) (
    input  logic          clk,
    input  logic          rst,
    input  logic [N-1:0]  req,
    input  logic          advance,
    output logic          found,
    output logic [IW-1:0] idx
);
    logic [IW-1:0] ptr;

    always_comb begin
        found = 1'b0;
        idx   = '0;
        for (int k = 0; k < N; k++) begin
            int c;
            c = int'(ptr) + k;
            if (c >= N) c = c - N;
            for (int j = 0; j < N; j++) begin
                if (!found && j == c && req[j]) begin
                    found = 1'b1;
                    idx   = IW'(j);
                end
            end
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            ptr <= '0;
        end else if (advance && found) begin
            ptr <= (int'(idx) == N - 1) ? '0 : idx + 1'b1;
        end
    end
endmodule

// File: rtl/rt_escape_vc_sel.sv
module rt_escape_vc_sel
    import rt_vc_pkg::*;
#(
    parameter int X_W     = 3,
    parameter int Y_W     = 3,
    parameter int NUM_AVC = 2,
    localparam int NUM_VC = NUM_AVC + 1,
    localparam int VC_W   = $clog2(NUM_VC),
    localparam int FREE_W = NUM_PORTS * NUM_VC
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              hdr_valid,
    input  logic [X_W-1:0]    cur_x,
    input  logic [Y_W-1:0]    cur_y,
    input  logic [X_W-1:0]    dst_x,
    input  logic [Y_W-1:0]    dst_y,
    input  logic              esc_in,
    input  logic [FREE_W-1:0] vc_free,
    output logic              grant,
    output logic [2:0]        out_port,
    output logic [VC_W-1:0]   out_vc,
    output logic              esc_out
);
    localparam int SLOTS  = 2 * NUM_AVC;
    localparam int SW     = (SLOTS > 1) ? $clog2(SLOTS) : 1;
    localparam int ESC_VC = NUM_AVC;

    function automatic logic chan_free(input logic [FREE_W-1:0] fv,
                                       input port_e p, input int v);
        logic r;
        r = 1'b0;
        for (int i = 0; i < FREE_W; i++) begin
            if (i == int'(p) * NUM_VC + v) r = fv[i];
        end
        return r;
    endfunction

    route_info_t info;

    rt_dir #(.X_W(X_W), .Y_W(Y_W)) u_dir (
        .cur_x(cur_x), .cur_y(cur_y), .dst_x(dst_x), .dst_y(dst_y), .info(info)
    );

    // Adaptive candidate slots: slot = 2*vc + dim (dim 0 = X, 1 = Y)
    logic [SLOTS-1:0] slot_req;
    for (genvar v = 0; v < NUM_AVC; v++) begin : g_vc
        for (genvar d = 0; d < 2; d++) begin : g_dim
            if (d == 0) begin : g_x
                assign slot_req[2*v+d] = info.x_move && chan_free(vc_free, info.x_port, v);
            end else begin : g_y
                assign slot_req[2*v+d] = info.y_move && chan_free(vc_free, info.y_port, v);
            end
        end
    end

    logic          rr_found;
    logic [SW-1:0] rr_idx;
    logic          rr_adv;

    rt_rr_pick #(.N(SLOTS)) u_rr (
        .clk(clk), .rst(rst), .req(slot_req), .advance(rr_adv),
        .found(rr_found), .idx(rr_idx)
    );

    logic            loc_found;
    logic [VC_W-1:0] loc_idx;

    rt_first_free #(.N(NUM_VC)) u_loc (
        .free(vc_free[int'(PORT_LOCAL)*NUM_VC +: NUM_VC]),
        .found(loc_found), .idx(loc_idx)
    );

    logic esc_free;
    assign esc_free = chan_free(vc_free, info.dor_port, ESC_VC);

    always_comb begin
        grant    = 1'b0;
        out_port = info.dor_port;
        out_vc   = VC_W'(ESC_VC);
        esc_out  = esc_in;
        rr_adv   = 1'b0;
        if (hdr_valid) begin
            if (info.at_dest) begin
                out_port = PORT_LOCAL;
                out_vc   = loc_idx;
                grant    = loc_found;
            end else if (!esc_in && rr_found) begin
                grant    = 1'b1;
                out_port = rr_idx[0] ? info.y_port : info.x_port;
                out_vc   = VC_W'(rr_idx >> 1);
                esc_out  = 1'b0;
                rr_adv   = 1'b1;
            end else if (esc_free) begin
                grant    = 1'b1;
                esc_out  = 1'b1;
            end
        end
    end
endmodule

// File: rtl/rt_escape_vc_sel_chk.sv
module rt_escape_vc_sel_chk #(
    parameter int X_W     = 3,
    parameter int Y_W     = 3,
    parameter int NUM_AVC = 2,
    localparam int NUM_VC = NUM_AVC + 1,
    localparam int VC_W   = $clog2(NUM_VC),
    localparam int FREE_W = 5 * NUM_VC
) (
    input logic              clk,
    input logic              rst,
    input logic              hdr_valid,
    input logic [X_W-1:0]    cur_x,
    input logic [Y_W-1:0]    cur_y,
    input logic [X_W-1:0]    dst_x,
    input logic [Y_W-1:0]    dst_y,
    input logic              esc_in,
    input logic [FREE_W-1:0] vc_free,
    input logic              grant,
    input logic [2:0]        out_port,
    input logic [VC_W-1:0]   out_vc,
    input logic              esc_out
);
    logic picked_free;
    always_comb begin
        picked_free = 1'b0;
        for (int i = 0; i < FREE_W; i++) begin
            if (i == int'(out_port) * NUM_VC + int'(out_vc)) picked_free = vc_free[i];
        end
    end

    logic arrived;
    assign arrived = (cur_x == dst_x) && (cur_y == dst_y);

    assert_idle_no_grant_R1: assert property (@(posedge clk) disable iff (rst)
        !hdr_valid |-> !grant);

    assert_arrival_local_R2: assert property (@(posedge clk) disable iff (rst)
        grant && arrived |-> out_port == 3'd0);

    assert_adaptive_range_R3: assert property (@(posedge clk) disable iff (rst)
        grant && !esc_out && out_port != 3'd0 |-> int'(out_vc) < NUM_AVC);

    assert_escape_channel_R5: assert property (@(posedge clk) disable iff (rst)
        grant && esc_out && out_port != 3'd0 |-> int'(out_vc) == NUM_AVC);

    assert_mode_hold_R6: assert property (@(posedge clk) disable iff (rst)
        !grant |-> esc_out == esc_in);

    assert_no_return_R7: assert property (@(posedge clk) disable iff (rst)
        esc_in |-> esc_out);

    assert_granted_free_R8: assert property (@(posedge clk) disable iff (rst)
        grant |-> picked_free);
endmodule

bind rt_escape_vc_sel rt_escape_vc_sel_chk #(
    .X_W(X_W), .Y_W(Y_W), .NUM_AVC(NUM_AVC)
) u_chk (
    .clk(clk), .rst(rst), .hdr_valid(hdr_valid),
    .cur_x(cur_x), .cur_y(cur_y), .dst_x(dst_x), .dst_y(dst_y),
    .esc_in(esc_in), .vc_free(vc_free), .grant(grant),
    .out_port(out_port), .out_vc(out_vc), .esc_out(esc_out)
);

// File: tb/rt_escape_vc_sel_tb.sv
module rt_escape_vc_sel_tb;
    localparam int CLK_PERIOD = 10;
    localparam int X_W = 3;
    localparam int Y_W = 3;
    localparam int NUM_AVC = 2;
    localparam int NUM_VC = NUM_AVC + 1;
    localparam int VC_W = $clog2(NUM_VC);
    localparam int FREE_W = 5 * NUM_VC;
    localparam logic [FREE_W-1:0] ALL = '1;

    logic clk = 1'b0;
    logic rst = 1'b1;
    logic hdr_valid = 1'b0;
    logic [X_W-1:0] cur_x = '0, dst_x = '0;
    logic [Y_W-1:0] cur_y = '0, dst_y = '0;
    logic esc_in = 1'b0;
    logic [FREE_W-1:0] vc_free = '0;
    logic grant, esc_out;
    logic [2:0] out_port;
    logic [VC_W-1:0] out_vc;

    int checks = 0;
    int fails = 0;
    bit done = 1'b0;

    always #(CLK_PERIOD/2) clk = ~clk;

    rt_escape_vc_sel #(.X_W(X_W), .Y_W(Y_W), .NUM_AVC(NUM_AVC)) u_dut (
        .clk(clk), .rst(rst), .hdr_valid(hdr_valid),
        .cur_x(cur_x), .cur_y(cur_y), .dst_x(dst_x), .dst_y(dst_y),
        .esc_in(esc_in), .vc_free(vc_free), .grant(grant),
        .out_port(out_port), .out_vc(out_vc), .esc_out(esc_out)
    );

    function automatic logic [FREE_W-1:0] bit_of(input int p, input int v);
        logic [FREE_W-1:0] m;
        m = '0;
        m[p*NUM_VC+v] = 1'b1;
        return m;
    endfunction

    task automatic do_reset();
        @(negedge clk);
        rst = 1'b1;
        hdr_valid = 1'b0;
        @(negedge clk);
        rst = 1'b0;
    endtask

    task automatic drive(input logic v, input int cx, input int cy, input int dx,
                         input int dy, input logic e, input logic [FREE_W-1:0] f);
        @(negedge clk);
        hdr_valid = v;
        cur_x = X_W'(cx); cur_y = Y_W'(cy);
        dst_x = X_W'(dx); dst_y = Y_W'(dy);
        esc_in = e;
        vc_free = f;
        #1;
    endtask

    task automatic expect_out(input string req, input logic g, input int p,
                              input int v, input logic e);
        checks++;
        if (grant !== g || (g && (int'(out_port) != p || int'(out_vc) != v)) || esc_out !== e) begin
            fails++;
            $display("FAIL %s: got grant=%0b port=%0d vc=%0d esc=%0b, expected grant=%0b port=%0d vc=%0d esc=%0b",
                     req, grant, out_port, out_vc, esc_out, g, p, v, e);
        end
    endtask

    // R1: idle after reset
    task automatic t_reset_idle();
        do_reset();
        drive(1'b0, 2, 2, 5, 6, 1'b0, ALL);
        expect_out("R1 idle", 1'b0, 0, 0, 1'b0);
    endtask

    // R3/R4: pointer rotates over slots, alternating dimension, and wraps
    task automatic t_round_robin();
        do_reset();
        drive(1'b1, 2, 2, 5, 6, 1'b0, ALL);
        expect_out("R4 slot0", 1'b1, 1, 0, 1'b0);
        drive(1'b1, 2, 2, 5, 6, 1'b0, ALL);
        expect_out("R4 slot1", 1'b1, 3, 0, 1'b0);
        drive(1'b1, 2, 2, 5, 6, 1'b0, ALL);
        expect_out("R4 slot2", 1'b1, 1, 1, 1'b0);
        drive(1'b1, 2, 2, 5, 6, 1'b0, ALL);
        expect_out("R4 slot3", 1'b1, 3, 1, 1'b0);
        drive(1'b1, 2, 2, 5, 6, 1'b0, ALL);
        expect_out("R4 wrap", 1'b1, 1, 0, 1'b0);
    endtask

    // R1/R4: pointer holds across an idle cycle
    task automatic t_idle_hold();
        do_reset();
        drive(1'b1, 2, 2, 5, 6, 1'b0, ALL);
        expect_out("R4 first", 1'b1, 1, 0, 1'b0);
        drive(1'b0, 2, 2, 5, 6, 1'b0, ALL);
        expect_out("R1 no grant", 1'b0, 0, 0, 1'b0);
        drive(1'b1, 2, 2, 5, 6, 1'b0, ALL);
        expect_out("R1 pointer held", 1'b1, 3, 0, 1'b0);
    endtask

    // R3/R6: only useful outputs count; blocked with busy escape
    task automatic t_partial();
        do_reset();
        drive(1'b1, 4, 4, 1, 0, 1'b0, bit_of(4, 1) | bit_of(1, 0));
        expect_out("R3 only useful", 1'b1, 4, 1, 1'b0);
        drive(1'b1, 4, 4, 1, 0, 1'b0,
              bit_of(1,0) | bit_of(1,1) | bit_of(1,2) | bit_of(3,0) | bit_of(3,1) | bit_of(3,2));
        expect_out("R6 escape busy", 1'b0, 0, 0, 1'b0);
    endtask

    // R5/R4: fallback to escape on X first; pointer unchanged afterwards
    task automatic t_escape_entry();
        do_reset();
        drive(1'b1, 4, 4, 1, 0, 1'b0, bit_of(2, 2) | bit_of(4, 2));
        expect_out("R5 escape entry", 1'b1, 2, 2, 1'b1);
        drive(1'b1, 4, 4, 1, 0, 1'b0, ALL);
        expect_out("R4 held after escape", 1'b1, 2, 0, 1'b0);
    endtask

    // R7/R6/R5: escape mode stays deterministic
    task automatic t_escape_mode();
        do_reset();
        drive(1'b1, 3, 1, 3, 5, 1'b1, ALL);
        expect_out("R7 escape only", 1'b1, 3, 2, 1'b1);
        drive(1'b1, 3, 1, 3, 5, 1'b1, ALL & ~bit_of(3, 2));
        expect_out("R7 no return", 1'b0, 0, 0, 1'b1);
        drive(1'b1, 3, 1, 0, 5, 1'b1, ALL);
        expect_out("R5 x first", 1'b1, 2, 2, 1'b1);
    endtask

    // R2/R8: arrival goes local, lowest free channel, either mode
    task automatic t_arrival();
        do_reset();
        drive(1'b1, 2, 3, 2, 3, 1'b0, ALL);
        expect_out("R2 local", 1'b1, 0, 0, 1'b0);
        drive(1'b1, 2, 3, 2, 3, 1'b0, ALL & ~bit_of(0, 0));
        expect_out("R8 local vc1", 1'b1, 0, 1, 1'b0);
        drive(1'b1, 2, 3, 2, 3, 1'b1, bit_of(0, 0));
        expect_out("R2 escape mode local", 1'b1, 0, 0, 1'b1);
        drive(1'b1, 2, 3, 2, 3, 1'b0, ALL & ~(bit_of(0,0) | bit_of(0,1) | bit_of(0,2)));
        expect_out("R2 local busy", 1'b0, 0, 0, 1'b0);
    endtask

    // R3/R8: Y-only route ignores free X channels
    task automatic t_y_only();
        do_reset();
        drive(1'b1, 1, 1, 1, 4, 1'b0, bit_of(1, 0) | bit_of(3, 1));
        expect_out("R3 y only", 1'b1, 3, 1, 1'b0);
    endtask

    initial begin
        t_reset_idle();
        t_round_robin();
        t_idle_hold();
        t_partial();
        t_escape_entry();
        t_escape_mode();
        t_arrival();
        t_y_only();
        done = 1'b1;
        $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            fails++;
            $display("FAIL watchdog: got timeout, expected completion");
            $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
            $finish;
        end
    end
endmodule